// File: doc/BRIEF.md
# Repeating DMA Burst Generator

This block is a bus-master traffic source for measuring how fast a host memory system absorbs DMA. Software sets up a run through a small register window: a word-aligned physical start address, a burst length in words, a number of bursts and a transfer direction. It then sets the start bit. The engine raises a bus request and holds it until the bus grants. It then moves exactly one word per cycle for the programmed length. After that it sits idle for a fixed seven-cycle gap, steps the address past the block just moved and requests again. This repeats until every burst has been issued.

The address space is treated as flat and physical. Each burst begins where the previous one ended. When the engine writes to the host, each outgoing word carries its running index within the run, so a checker can spot lost or duplicated beats. When it reads, the returned words are folded into a running sum. A cycle counter runs for as long as the engine is busy and then freezes. Software divides the words moved by the counted cycles to get throughput.

Top module: `dma_burst_gen`

## Requirements
- R1: After reset, busy is 0, bus_req is 0, the elapsed-cycle and checksum registers read 0, and the length register reads 1.
- R2: Register window, selected by byte offset on reg_addr: 0x00 start address, 0x04 burst length, 0x08 burst count, 0x0C control, 0x10 elapsed cycles (read-only), 0x14 checksum (read-only). In control, bit 0 written as 1 starts a run, bit 1 is the direction (1 = write to host, 0 = read from host), and bit 2 reads the busy flag. Bits 1:0 of the start address always read as 0.
- R3: Word k of a run (counting from 0 across all bursts) is transferred at start address + 4·k. So each burst begins at the previous burst's base plus length·4.
- R4: bus_req stays high from the first request cycle until the grant, and through the burst. It is low on the cycle after the last word.
- R5: Once granted, a burst presents bus_xfer on exactly `length` consecutive cycles, one word per cycle.
- R6: Between the last word of one burst and the next request, exactly 7 cycles pass with bus_req low.
- R7: In write direction, bus_we is 1 and bus_wdata carries the run's word index, starting at 0. In read direction, bus_we is 0.
- R8: In read direction, the checksum register holds the sum modulo 2^32 of every bus_rdata word accepted during the run. It is cleared when a run starts.
- R9: Busy is set from the cycle after start until the last word of the last burst. The elapsed-cycle register counts every cycle in that span, which is N·(1+W+L) + 7·(N−1) for N bursts of L words with W grant-wait cycles each. It then holds its value.
- R10: A start written while busy has no effect on the run in progress, including its direction. A start with a burst count of 0 does not set busy and issues no request.
- R11: A length write of 0 stores 1, and a length write above 128 stores 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant, sampled while requesting |
| bus_xfer | output | 1 | A word moves in this cycle |
| bus_we | output | 1 | 1 = write to host, 0 = read from host |
| bus_addr | output | 32 | Physical byte address of the current word |
| bus_wdata | output | 32 | Data sent to host in write direction |
| bus_rdata | input | 32 | Data returned by host in read direction |

## Verification
A stray beat counter or a misloaded base shows up at the ports within one word. The address or the write index breaks its step of 4 or 1, or the burst boundary lands in the wrong cycle, and the scoreboard catches that on that very transfer. A gap or grant-wait error changes the spacing between the last word of one burst and the first of the next, and shifts the final cycle count by a predictable amount. A checksum or counter fault stays hidden until the run ends and the registers are read back, but the mismatch is then exact. A start that wrongly restarts a busy engine shows up as an address that jumps back to the base.

// File: rtl/dma_burst_gen.sv
module dma_burst_gen #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MAX_LEN = 128,
  parameter int GAP     = 7,
  parameter int CNT_W   = 16,
  parameter int CYC_W   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_xfer,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int GAP_W = $clog2(GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER, S_GAP} state_t;
  state_t state;

  logic [AW-1:0]    cfg_addr, base;
  logic [LEN_W-1:0] cfg_len, run_len, beat;
  logic [CNT_W-1:0] cfg_cnt, left;
  logic             cfg_dir, run_dir;
  logic [GAP_W-1:0] gap_c;
  logic [DW-1:0]    widx, csum;
  logic [CYC_W-1:0] cycles;

  wire busy     = (state != S_IDLE);
  wire ctrl_wr  = reg_we && (reg_addr == 5'h0C);
  wire go       = ctrl_wr && reg_wdata[0] && !busy && (cfg_cnt != '0);
  wire last_bt  = (beat == run_len - LEN_W'(1));

  assign bus_req   = (state == S_REQ) || (state == S_XFER);
  assign bus_xfer  = (state == S_XFER);
  assign bus_we    = run_dir;
  assign bus_wdata = widx;
  assign bus_addr  = base + AW'({beat, 2'b00});

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = 32'(cfg_addr);
      5'h04:   reg_rdata = 32'(cfg_len);
      5'h08:   reg_rdata = 32'(cfg_cnt);
      5'h0C:   reg_rdata = {29'd0, busy, cfg_dir, 1'b0};
      5'h10:   reg_rdata = 32'(cycles);
      5'h14:   reg_rdata = 32'(csum);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      cfg_len  <= LEN_W'(1);
      cfg_cnt  <= '0;
      cfg_dir  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        5'h00: cfg_addr <= {reg_wdata[AW-1:2], 2'b00};
        5'h04: begin
          if (reg_wdata == 32'd0)        cfg_len <= LEN_W'(1);
          else if (reg_wdata > MAX_LEN)  cfg_len <= LEN_W'(MAX_LEN);
          else                           cfg_len <= reg_wdata[LEN_W-1:0];
        end
        5'h08: cfg_cnt <= reg_wdata[CNT_W-1:0];
        5'h0C: cfg_dir <= reg_wdata[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      base    <= '0;
      run_len <= LEN_W'(1);
      run_dir <= 1'b0;
      beat    <= '0;
      left    <= '0;
      gap_c   <= '0;
      widx    <= '0;
      csum    <= '0;
      cycles  <= '0;
    end else begin
      if (busy) cycles <= cycles + CYC_W'(1);
      case (state)
        S_IDLE: if (go) begin
          state   <= S_REQ;
          base    <= cfg_addr;
          run_len <= cfg_len;
          run_dir <= reg_wdata[1];
          left    <= cfg_cnt;
          widx    <= '0;
          csum    <= '0;
          cycles  <= '0;
          beat    <= '0;
        end
        S_REQ: if (bus_gnt) begin
          state <= S_XFER;
          beat  <= '0;
        end
        S_XFER: begin
          widx <= widx + DW'(1);
          if (!run_dir) csum <= csum + bus_rdata;
          if (last_bt) begin
            base  <= base + AW'({run_len, 2'b00});
            beat  <= '0;
            left  <= left - CNT_W'(1);
            gap_c <= '0;
            state <= (left == CNT_W'(1)) ? S_IDLE : S_GAP;
          end else begin
            beat <= beat + LEN_W'(1);
          end
        end
        S_GAP: begin
          if (gap_c == GAP_W'(GAP - 1)) state <= S_REQ;
          else gap_c <= gap_c + GAP_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  localparam int IW = GAP_W + 1;
  logic [IW-1:0] idle_n;
  logic          had_burst;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_n    <= '0;
      had_burst <= 1'b0;
    end else begin
      if (bus_req) idle_n <= '0;
      else if (idle_n != IW'(GAP + 1)) idle_n <= idle_n + IW'(1);
      had_burst <= !busy ? 1'b0 : (bus_xfer ? 1'b1 : had_burst);
    end
  end

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_xfer && $past(bus_xfer) |-> bus_addr == $past(bus_addr) + AW'(4));
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !bus_xfer |=> bus_req && !bus_xfer);
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_xfer) |-> !bus_req);
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && had_burst |-> idle_n == IW'(GAP));
  p_wdata_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_xfer && $past(bus_xfer) && bus_we |-> bus_wdata == $past(bus_wdata) + DW'(1));
  p_cycles_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $past(rst_n) |-> $stable(cycles));
endmodule

// File: tb/dma_burst_gen_test.sv
`timescale 1ns/1ps
module dma_burst_gen_test;
  localparam int GAP = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req, bus_xfer, bus_we;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0, n_bad = 0;
  int lat = 0, wait_c = 0;
  int cyc_now = 0, last_stamp = 0;
  logic [31:0] q_addr[$], q_data[$];
  logic        q_we[$];
  int          q_dt[$];

  dma_burst_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_xfer(bus_xfer), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return (a * 32'd3) ^ 32'hC3C3_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // host model: grant after lat wait cycles, read data from address
  always @(negedge clk) begin
    cyc_now++;
    bus_rdata = rd_pat(bus_addr);
    if (bus_req && !bus_xfer) begin
      bus_gnt = (wait_c == lat);
      wait_c++;
    end else begin
      bus_gnt = 1'b0;
      wait_c = 0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_xfer) begin
      if (q_addr.size() == 0) begin
        check("R5 unexpected word", bus_addr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea, ed; logic ew; int dt;
        ea = q_addr.pop_front(); ed = q_data.pop_front();
        ew = q_we.pop_front();   dt = q_dt.pop_front();
        check("R3 address", bus_addr, ea);
        check("R7 direction", 32'(bus_we), 32'(ew));
        if (ew) check("R7 write index", bus_wdata, ed);
        if (dt != 0) check("R5/R6 word spacing", 32'(cyc_now - last_stamp), 32'(dt));
      end
      last_stamp = cyc_now;
    end
  end

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic run_case(input logic [31:0] addr, input int len, input int cnt,
                          input logic dir, input int l, input bit poke);
    logic [31:0] sum, v;
    int guard;
    sum = '0;
    lat = l;
    reg_write(5'h00, addr);
    reg_write(5'h04, 32'(len));
    reg_write(5'h08, 32'(cnt));
    for (int b = 0; b < cnt; b++)
      for (int w = 0; w < len; w++) begin
        logic [31:0] a;
        a = addr + 32'((b * len + w) * 4);
        q_addr.push_back(a);
        q_data.push_back(32'(b * len + w));
        q_we.push_back(dir);
        q_dt.push_back(w != 0 ? 1 : (b == 0 ? 0 : GAP + 2 + l));
        sum += rd_pat(a);
      end
    reg_write(5'h0C, {30'd0, dir, 1'b1});
    if (poke) begin
      repeat (3) @(negedge clk);
      reg_write(5'h0C, {30'd0, ~dir, 1'b1}); // R10 restart ignored
    end
    guard = 0;
    do begin
      reg_read(5'h0C, v);
      guard++;
    end while (v[2] && guard < 5000);
    check("R9 busy cleared", 32'(v[2]), 32'd0);
    check("R5 all words moved", 32'(q_addr.size()), 32'd0);
    q_addr.delete(); q_data.delete(); q_we.delete(); q_dt.delete();
    reg_read(5'h10, v);
    check("R9 elapsed cycles", v, 32'(cnt * (1 + l + len) + GAP * (cnt - 1)));
    reg_read(5'h14, v);
    check("R8 checksum", v, dir ? 32'd0 : sum);
    check("R4 request low when idle", 32'(bus_req), 32'd0);
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_read(5'h0C, v);  check("R1 busy at reset", 32'(v[2]), 32'd0);
    check("R1 request at reset", 32'(bus_req), 32'd0);
    reg_read(5'h10, v);  check("R1 cycles at reset", v, 32'd0);
    reg_read(5'h14, v);  check("R1 checksum at reset", v, 32'd0);
    reg_read(5'h04, v);  check("R1 length at reset", v, 32'd1);

    reg_write(5'h00, 32'h0000_3003);
    reg_read(5'h00, v);  check("R2 address alignment", v, 32'h0000_3000);
    reg_write(5'h04, 32'd0);
    reg_read(5'h04, v);  check("R11 length zero", v, 32'd1);
    reg_write(5'h04, 32'd200);
    reg_read(5'h04, v);  check("R11 length clamp", v, 32'd128);

    run_case(32'h0000_1000, 4, 3, 1'b1, 0, 1'b0);
    run_case(32'h0000_2004, 5, 2, 1'b0, 3, 1'b0);
    run_case(32'h0001_0000, 128, 2, 1'b1, 1, 1'b0);
    run_case(32'h0000_0040, 1, 4, 1'b1, 0, 1'b0);
    run_case(32'h0002_0000, 64, 2, 1'b0, 0, 1'b0);
    run_case(32'h0000_5000, 6, 3, 1'b1, 2, 1'b1);   // R10 start while busy
    run_case(32'h0000_6000, 6, 2, 1'b0, 0, 1'b1);   // R10 direction kept

    reg_read(5'h10, v);
    repeat (10) @(negedge clk);
    reg_read(5'h10, v2); check("R9 counter frozen", v2, v);

    reg_write(5'h08, 32'd0);
    reg_write(5'h0C, 32'd3);
    repeat (5) @(negedge clk);
    reg_read(5'h0C, v);  check("R10 zero count no busy", 32'(v[2]), 32'd0);
    check("R10 zero count no request", 32'(bus_req), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule